// File: doc/BRIEF.md
# Host-Driven Buffer Transfer Engine

This block moves data between a host-visible data port and a small packet buffer RAM held inside it. The host loads a start address and a byte count through byte-wide configuration registers. It then issues a command that opens a read or a write transfer. After that, every strobe on the data port moves one byte, or one 16-bit word when word mode is on. Each strobe also advances the buffer address and reduces the remaining count.

The transfer ends by itself on the strobe that uses up the count. At that point a sticky completion flag is raised. The host has to clear that flag before another transfer is accepted. A stop command ends a transfer at once without raising the flag. Strobes that arrive while no transfer is open do nothing.

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle (`dma_busy` = 0), the completion flag is 0, and address, count and word mode are all 0.
- R2: Register select 1 loads the address low byte, 2 the address high byte, 3 the count low byte, 4 the count high byte, and 6 the mode (bit 0 = word mode). Writing select 0 with bits [2:0] = 3'b001 opens a read and 3'b010 opens a write. Any other value with bit 2 clear opens nothing.
- R3: In byte mode, a write strobe stores `dp_wdata[7:0]` at the current address, and `dp_rdata` shows {8'h00, byte at address}. Each accepted strobe adds 1 to the address and takes 1 from the count.
- R4: In word mode, a write strobe stores the low byte at the address and the high byte at address+1. `dp_rdata` shows {byte at address+1, byte at address}. Each accepted strobe adds 2 to the address and takes 2 from the count. The buffer index is the low address bits and wraps around.
- R5: The strobe accepted while the count is at most the step size (1 in byte mode, 2 in word mode) ends the transfer. `dma_busy` falls and `dma_done` rises at that clock edge. So an odd count in word mode ends after the rounded-up number of words.
- R6: `dma_done` stays set until the host writes select 5 with bit 0 = 1. While it is set, a read or write command does not open a transfer.
- R7: A start command given while the count is 0 leaves the engine idle and `dma_done` at 0.
- R8: A command write with bit 2 set closes an open transfer at the next edge, and `dma_done` stays 0. Given while idle, the stop command has no effect.
- R9: A strobe while idle, or a strobe of the opposite direction during a transfer, changes neither the buffer nor the address.
- R10: While a transfer is open, writes to the address, count, mode and start registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Configuration register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| dp_rd | input | 1 | Data port read strobe (pops the shown data) |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | 16 | Data port write data |
| dp_rdata | output | 16 | Data at the current buffer address |
| dma_busy | output | 1 | Transfer open |
| dma_done | output | 1 | Sticky completion flag |

## Verification
The hardest situations to reach are register and strobe traffic that collides with an open transfer. Examples are a stop command in the middle of a transfer, an address or count rewrite halfway through, and a strobe in the wrong direction. Each of these only matters when the buffer is read back afterwards. So the stimulus first fills the whole buffer in word mode. It then opens byte and word transfers and drives those collisions inside them. After that it reopens read transfers over the same region, so that every misplaced byte or skipped address shows on `dp_rdata`. A behavioural model steps alongside the design and is compared on every clock.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {XF_IDLE = 2'd0, XF_READ = 2'd1, XF_WRITE = 2'd2} xfer_e;

  localparam logic [2:0] SEL_CMD     = 3'd0;
  localparam logic [2:0] SEL_ADDR_LO = 3'd1;
  localparam logic [2:0] SEL_ADDR_HI = 3'd2;
  localparam logic [2:0] SEL_CNT_LO  = 3'd3;
  localparam logic [2:0] SEL_CNT_HI  = 3'd4;
  localparam logic [2:0] SEL_STAT    = 3'd5;
  localparam logic [2:0] SEL_MODE    = 3'd6;

  localparam logic [2:0] CMD_READ  = 3'b001;
  localparam logic [2:0] CMD_WRITE = 3'b010;
  localparam int         CMD_STOP_BIT = 2;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              dp_rd,
  input  logic              dp_wr,
  output xfer_e             xfer_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              word_q,
  output logic              beat_o,
  output logic              done_q
);
  localparam int ADDR_HI_W = ADDR_W - 8;
  localparam int CNT_HI_W  = CNT_W - 8;

  xfer_e             xfer_d;
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              word_d, done_d;
  logic              xfer_en, addr_en, cnt_en, word_en, done_en;

  logic              cmd_wr, stop_req, rd_req, wr_req;
  logic [CNT_W-1:0]  cnt_step;
  logic [ADDR_W-1:0] addr_step;
  logic              last_beat;

  always_comb begin
    cmd_wr    = reg_we && (reg_sel == SEL_CMD);
    stop_req  = cmd_wr && reg_wdata[CMD_STOP_BIT];
    rd_req    = cmd_wr && (reg_wdata[2:0] == CMD_READ);
    wr_req    = cmd_wr && (reg_wdata[2:0] == CMD_WRITE);
    cnt_step  = word_q ? CNT_W'(2) : CNT_W'(1);
    addr_step = word_q ? ADDR_W'(2) : ADDR_W'(1);
    last_beat = (cnt_q <= cnt_step);
    beat_o    = ((xfer_q == XF_READ) && dp_rd) || ((xfer_q == XF_WRITE) && dp_wr);
  end

  always_comb begin
    xfer_d  = xfer_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    done_d  = done_q;
    xfer_en = 1'b0;
    addr_en = 1'b0;
    cnt_en  = 1'b0;
    word_en = 1'b0;
    done_en = 1'b0;
    if (xfer_q != XF_IDLE) begin
      if (stop_req) begin
        xfer_d  = XF_IDLE;
        xfer_en = 1'b1;
      end else if (beat_o) begin
        addr_d  = addr_q + addr_step;
        addr_en = 1'b1;
        cnt_en  = 1'b1;
        if (last_beat) begin
          cnt_d   = '0;
          xfer_d  = XF_IDLE;
          xfer_en = 1'b1;
          done_d  = 1'b1;
          done_en = 1'b1;
        end else begin
          cnt_d = cnt_q - cnt_step;
        end
      end
    end else if (reg_we) begin
      unique case (reg_sel)
        SEL_ADDR_LO: begin
          addr_d  = {addr_q[ADDR_W-1:8], reg_wdata};
          addr_en = 1'b1;
        end
        SEL_ADDR_HI: begin
          addr_d  = {reg_wdata[ADDR_HI_W-1:0], addr_q[7:0]};
          addr_en = 1'b1;
        end
        SEL_CNT_LO: begin
          cnt_d  = {cnt_q[CNT_W-1:8], reg_wdata};
          cnt_en = 1'b1;
        end
        SEL_CNT_HI: begin
          cnt_d  = {reg_wdata[CNT_HI_W-1:0], cnt_q[7:0]};
          cnt_en = 1'b1;
        end
        SEL_MODE: begin
          word_d  = reg_wdata[0];
          word_en = 1'b1;
        end
        SEL_STAT: begin
          if (reg_wdata[0]) begin
            done_d  = 1'b0;
            done_en = 1'b1;
          end
        end
        SEL_CMD: begin
          if ((rd_req || wr_req) && !done_q && (cnt_q != '0)) begin
            xfer_d  = rd_req ? XF_READ : XF_WRITE;
            xfer_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= XF_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      word_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (xfer_en) xfer_q <= xfer_d;
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (word_en) word_q <= word_d;
      if (done_en) done_q <= done_d;
    end
  end
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf #(
  parameter int BYTES = 256,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wide,
  input  logic [AW-1:0] idx,
  input  logic [15:0]   wdata,
  output logic [7:0]    rdata_lo,
  output logic [7:0]    rdata_hi
);
  logic [7:0]    mem [BYTES];
  logic [AW-1:0] idx_nx;

  always_comb begin
    idx_nx   = idx + AW'(1);
    rdata_lo = mem[idx];
    rdata_hi = mem[idx_nx];
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata[7:0];
      if (wide) mem[idx_nx] <= wdata[15:8];
    end
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        dma_busy,
  output logic        dma_done
);
  localparam int BUF_AW = $clog2(BUF_BYTES);

  xfer_e             xfer;
  logic [ADDR_W-1:0] addr;
  logic              word_mode, beat, ram_we;
  logic [7:0]        rd_lo, rd_hi;

  rdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
    .xfer_q(xfer), .addr_q(addr), .word_q(word_mode), .beat_o(beat),
    .done_q(dma_done)
  );

  always_comb ram_we = beat && (xfer == XF_WRITE);

  rdma_buf #(.BYTES(BUF_BYTES), .AW(BUF_AW)) u_buf (
    .clk(clk), .we(ram_we), .wide(word_mode), .idx(addr[BUF_AW-1:0]),
    .wdata(dp_wdata), .rdata_lo(rd_lo), .rdata_hi(rd_hi)
  );

  always_comb begin
    dp_rdata = word_mode ? {rd_hi, rd_lo} : {8'h00, rd_lo};
    dma_busy = (xfer != XF_IDLE);
  end
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [7:0]  reg_wdata,
  input logic [15:0] dp_rdata,
  input logic        dma_busy,
  input logic        dma_done
);
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_busy && dma_done));

  assert_done_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_done) |-> $past(dma_busy));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && !(reg_we && reg_sel == 3'd5 && reg_wdata[0])) |=> (dma_done && !dma_busy));

  assert_stop_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && reg_we && reg_sel == 3'd0 && reg_wdata[2]) |=> (!dma_busy && !dma_done));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_busy && !reg_we) |=> (!dma_busy && $stable(dp_rdata)));
endmodule

bind rdma_engine rdma_engine_chk u_chk (.*);

// File: tb/tb_rdma_engine.sv
module tb_rdma_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic        dp_rd, dp_wr;
  logic [15:0] dp_wdata;
  logic [15:0] dp_rdata;
  logic        dma_busy, dma_done;

  always #5 clk = ~clk;

  rdma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .dma_busy(dma_busy), .dma_done(dma_done)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur = "R1";

  int mem [256];
  int m_state, m_addr, m_cnt, m_done, m_word;

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    int idx, lo, hi;
    idx = m_addr % 256;
    lo  = mem[idx];
    hi  = mem[(idx + 1) % 256];
    if (lo < 0) return -1;
    if (m_word != 0) begin
      if (hi < 0) return -1;
      return hi * 256 + lo;
    end
    return lo;
  endfunction

  function automatic void model_step(bit we, int sel, int wd, bit rd, bit wr, int wdat);
    int step;
    step = (m_word != 0) ? 2 : 1;
    if (m_state != 0) begin
      if (we && sel == 0 && ((wd >> 2) & 1) == 1) m_state = 0;
      else if ((m_state == 1 && rd) || (m_state == 2 && wr)) begin
        if (m_state == 2) begin
          mem[m_addr % 256] = wdat & 255;
          if (m_word != 0) mem[(m_addr + 1) % 256] = (wdat >> 8) & 255;
        end
        m_addr = (m_addr + step) & 16'hFFFF;
        if (m_cnt <= step) begin
          m_cnt = 0; m_state = 0; m_done = 1;
        end else m_cnt = m_cnt - step;
      end
    end else if (we) begin
      case (sel)
        1: m_addr = (m_addr & 16'hFF00) | wd;
        2: m_addr = (m_addr & 16'h00FF) | (wd << 8);
        3: m_cnt  = (m_cnt & 16'hFF00) | wd;
        4: m_cnt  = (m_cnt & 16'h00FF) | (wd << 8);
        5: if ((wd & 1) != 0) m_done = 0;
        6: m_word = wd & 1;
        0: if (((wd & 7) == 1 || (wd & 7) == 2) && m_done == 0 && m_cnt != 0)
             m_state = wd & 7;
        default: ;
      endcase
    end
  endfunction

  task automatic cyc(bit we, int sel, int wd, bit rd, bit wr, int wdat);
    int e;
    reg_we    = we;
    reg_sel   = 3'(sel);
    reg_wdata = 8'(wd);
    dp_rd     = rd;
    dp_wr     = wr;
    dp_wdata  = 16'(wdat);
    model_step(we, sel, wd, rd, wr, wdat);
    @(posedge clk);
    @(negedge clk);
    check_eq({cur, " busy"}, int'(dma_busy), int'(m_state != 0));
    check_eq({cur, " done"}, int'(dma_done), m_done);
    e = exp_rdata();
    if (e >= 0) check_eq({cur, " rdata"}, int'(dp_rdata), e);
    reg_we = 1'b0; dp_rd = 1'b0; dp_wr = 1'b0;
  endtask

  task automatic regw(int sel, int val);
    cyc(1'b1, sel, val, 1'b0, 1'b0, 0);
  endtask

  task automatic setup(int a, int c, int w);
    regw(1, a & 255); regw(2, (a >> 8) & 255);
    regw(3, c & 255); regw(4, (c >> 8) & 255);
    regw(6, w);
  endtask

  task automatic bwr(int d);
    cyc(1'b0, 0, 0, 1'b0, 1'b1, d);
  endtask

  task automatic brd();
    cyc(1'b0, 0, 0, 1'b1, 1'b0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mem[i]) mem[i] = -1;
    m_state = 0; m_addr = 0; m_cnt = 0; m_done = 0; m_word = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    dp_rd = 1'b0; dp_wr = 1'b0; dp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 busy after reset", int'(dma_busy), 0);
    check_eq("R1 done after reset", int'(dma_done), 0);

    // R4: word-mode fill of the whole buffer, index wraps at the end
    cur = "R4";
    setup(0, 256, 1);
    regw(0, 2);
    for (int i = 0; i < 128; i++) bwr((i * 16'h0103) ^ 16'h5A3C);
    check_eq("R5 done after full fill", int'(dma_done), 1);
    cur = "R6";
    regw(5, 1);
    check_eq("R6 done cleared", int'(dma_done), 0);

    // R3: byte-mode read of five bytes
    cur = "R3";
    setup(16'h0010, 5, 0);
    regw(0, 1);
    for (int i = 0; i < 5; i++) brd();
    check_eq("R3 done after byte read", int'(dma_done), 1);

    // R6: start blocked while done set
    cur = "R6";
    setup(16'h0010, 2, 0);
    regw(0, 1);
    check_eq("R6 start blocked by done", int'(dma_busy), 0);
    regw(5, 0);
    check_eq("R6 clear with bit0=0 keeps done", int'(dma_done), 1);
    regw(5, 1);

    // R9 / R10: wrong-direction strobe and register writes mid-transfer
    cur = "R9";
    setup(16'h0040, 3, 0);
    regw(0, 2);
    brd();
    bwr(16'h11AA);
    cur = "R10";
    regw(1, 16'h80);
    regw(3, 9);
    regw(6, 1);
    regw(0, 1);
    bwr(16'h22BB);
    bwr(16'h33CC);
    check_eq("R10 transfer ended on original count", int'(dma_done), 1);
    regw(5, 1);
    setup(16'h0040, 3, 0);
    regw(0, 1);
    check_eq("R9 byte at 0x40", int'(dp_rdata), 16'h00AA);
    brd();
    check_eq("R10 byte at 0x41", int'(dp_rdata), 16'h00BB);
    brd();
    brd();
    regw(5, 1);

    // R9: strobes while idle do nothing
    cur = "R9";
    setup(16'h0040, 1, 0);
    bwr(16'h0077);
    brd();
    regw(0, 1);
    check_eq("R9 idle write ignored", int'(dp_rdata), 16'h00AA);
    brd();
    regw(5, 1);

    // R7: zero count start
    cur = "R7";
    setup(16'h0020, 0, 0);
    regw(0, 1);
    check_eq("R7 zero count stays idle", int'(dma_busy), 0);
    check_eq("R7 zero count no done", int'(dma_done), 0);

    // R8: stop mid-transfer, then stop while idle
    cur = "R8";
    setup(16'h0030, 6, 0);
    regw(0, 2);
    bwr(16'h00E1);
    bwr(16'h00E2);
    regw(0, 4);
    check_eq("R8 stop closes transfer", int'(dma_busy), 0);
    check_eq("R8 stop leaves done clear", int'(dma_done), 0);
    regw(0, 4);
    check_eq("R8 idle stop no effect", int'(dma_done), 0);
    regw(0, 1);
    for (int i = 0; i < 4; i++) brd();
    check_eq("R8 resumed read completes", int'(dma_done), 1);
    regw(5, 1);

    // R5: odd count in word mode rounds up
    cur = "R5";
    setup(16'h0050, 3, 1);
    regw(0, 2);
    bwr(16'hA1B2);
    check_eq("R5 still open after one word", int'(dma_busy), 1);
    bwr(16'hC3D4);
    check_eq("R5 done after two words", int'(dma_done), 1);
    regw(5, 1);
    setup(16'h0050, 4, 1);
    regw(0, 1);
    check_eq("R4 word read order", int'(dp_rdata), 16'hA1B2);
    brd();
    brd();
    regw(5, 1);

    // R2: invalid command values do not start
    cur = "R2";
    setup(16'h0060, 4, 0);
    regw(0, 3);
    check_eq("R2 code 011 ignored", int'(dma_busy), 0);
    regw(0, 0);
    check_eq("R2 code 000 ignored", int'(dma_busy), 0);
    regw(0, 2);
    check_eq("R2 write command opens", int'(dma_busy), 1);
    regw(0, 4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule